// File: doc/BRIEF.md
# Gain-Dependent Settling Violation Monitor

This block sits beside a multiplexed ADC front end and watches the conversion-start strobe. Each start opens a settling window. The window length depends on the gain code and the resolution select that are present at that start. If another start arrives before the window has run out, the block sets a sticky clock-error flag. The monitor only reports the violation: the conversion itself goes ahead.

The monitor has no view of which channel is being converted. Sampling a single channel faster than the window therefore raises the flag even when the data is good. Window lengths are parameters given in microseconds. They are converted to clock cycles through a clock-frequency parameter (`CLK_MHZ`) and stored in a small table indexed by {resolution, gain code}. A one-cycle clear strobe from software drops the flag.

Top module: `settle_monitor`

## Requirements
- R1: After reset, `errFlag` and `busy` are both 0.
- R2: With `resSel`=0 (12-bit), gain codes 0 to 4 (×1, ×2, ×4, ×8, ×10) select a 10 µs window of N = 10·CLK_MHZ cycles. After the edge that samples a start, `busy` is high for exactly N−1 cycles.
- R3: With `resSel`=0, gain codes 5 and 6 (×100, ×1000) select a 30 µs window, so `busy` stays high for 30·CLK_MHZ−1 cycles.
- R4: With `resSel`=1 (16-bit), gain codes 0 and 1 (×1, ×2) select a 5 µs window, and gain codes 2 and 3 (×4, ×8) select a 20 µs window.
- R5: A start sampled while `busy` is 1 sets `errFlag` on that edge, so the flag is 1 from the next cycle on.
- R6: A start sampled exactly N edges after the previous start, when `busy` has just returned to 0, leaves `errFlag` unchanged.
- R7: `errFlag` stays 1 until a cycle in which `errClr` is 1. It is 0 after that edge, provided no violation occurs in the same cycle.
- R8: When `errClr` and a violating start are sampled on the same edge, `errFlag` ends up 1.
- R9: Every start restarts the window, including a violating one. The window is then counted from the latest start.
- R10: The window length is taken from `gainCode` and `resSel` at the start. Changes to them while the window runs have no effect on it.
- R11: The unused codes fall back to the longest window of their resolution: gain code 7 with `resSel`=0 gives 30 µs, and gain codes 4 to 7 with `resSel`=1 give 20 µs.
- R12: Reset clears the timer as well as the flag. The first start after reset never sets `errFlag`, even if reset arrived in the middle of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convStart | input | 1 | One-cycle conversion-start strobe |
| gainCode | input | GAIN_W | Gain code sampled at each start |
| resSel | input | 1 | 0 selects the 12-bit table, 1 selects the 16-bit table |
| errClr | input | 1 | One-cycle clear strobe for the error flag |
| errFlag | output | 1 | Sticky settling-violation flag |
| busy | output | 1 | High while a start would be a violation |

## Verification
Both results are registered one clock edge after the stimulus. `errFlag` reflects a start or a clear from the following cycle on. `busy` rises in the cycle after a start and falls N−1 cycles later. The bench therefore drives inputs on the falling edge and samples on the next falling edge. It measures window lengths by counting the falling-edge samples in which `busy` is high. Spacing tests place the second start exactly N−1 or N rising edges after the first, which pins down the boundary at which the flag sets.

// File: rtl/settle_pkg.sv
package settle_pkg;

  typedef struct packed {
    logic loadTimer;
    logic setErr;
    logic clrErr;
  } settleCtrl_t;

  function automatic int winUs(input int res, input int gain,
                               input int fast12, input int slow12,
                               input int fast16, input int slow16);
    if (res == 0) return (gain <= 4) ? fast12 : slow12;
    else          return (gain <= 1) ? fast16 : slow16;
  endfunction

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/settle_ctrl.sv
module settle_ctrl
  import settle_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        convStart,
  input  logic        errClr,
  input  logic        timerBusy,
  output settleCtrl_t ctrl
);

  always_comb begin
    ctrl.loadTimer = convStart;
    ctrl.setErr    = convStart & timerBusy;
    ctrl.clrErr    = errClr;
  end

  // R9: every start, violating or not, must reload the timer
  p_violation_reloads_r9: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> timerBusy);

endmodule

// File: rtl/settle_datapath.sv
module settle_datapath
  import settle_pkg::*;
#(
  parameter int GAIN_W    = 3,
  parameter int CLK_MHZ   = 250,
  parameter int FAST12_US = 10,
  parameter int SLOW12_US = 30,
  parameter int FAST16_US = 5,
  parameter int SLOW16_US = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  settleCtrl_t       ctrl,
  input  logic [GAIN_W-1:0] gainCode,
  input  logic              resSel,
  output logic              timerBusy,
  output logic              errFlag
);

  localparam int TBL_N   = 2 << GAIN_W;
  localparam int MAX_CYC = CLK_MHZ * maxOf4(FAST12_US, SLOW12_US, FAST16_US, SLOW16_US);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] winTable [TBL_N];
  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] loadVal;
  logic [GAIN_W:0]  tblIdx;

  for (genvar i = 0; i < TBL_N; i++) begin : g_win
    localparam int RES  = i >> GAIN_W;
    localparam int GAIN = i % (1 << GAIN_W);
    localparam int CYC  = CLK_MHZ * winUs(RES, GAIN, FAST12_US, SLOW12_US,
                                          FAST16_US, SLOW16_US);
    assign winTable[i] = CNT_W'(CYC);
  end

  assign tblIdx  = {resSel, gainCode};
  assign loadVal = winTable[tblIdx] - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)                remaining <= '0;
    else if (ctrl.loadTimer)  remaining <= loadVal;
    else if (remaining != '0) remaining <= remaining - CNT_W'(1);
  end

  assign timerBusy = (remaining != '0);

  always_ff @(posedge clk) begin
    if (!rstN)            errFlag <= 1'b0;
    else if (ctrl.setErr) errFlag <= 1'b1;
    else if (ctrl.clrErr) errFlag <= 1'b0;
  end

  // R2: an unreloaded window counts down by one each cycle
  p_countdown_r2: assert property (@(posedge clk) disable iff (!rstN)
    timerBusy && !ctrl.loadTimer |=> remaining == $past(remaining) - CNT_W'(1));

  // R7: the flag holds without a clear
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !ctrl.clrErr |=> errFlag);

  // R8: a violation beats a simultaneous clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.setErr && ctrl.clrErr |=> errFlag);

  // R5: the flag only rises because of a violation
  p_rise_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(ctrl.setErr));

endmodule

// File: rtl/settle_monitor.sv
module settle_monitor
  import settle_pkg::*;
#(
  parameter int GAIN_W    = 3,
  parameter int CLK_MHZ   = 250,
  parameter int FAST12_US = 10,
  parameter int SLOW12_US = 30,
  parameter int FAST16_US = 5,
  parameter int SLOW16_US = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convStart,
  input  logic [GAIN_W-1:0] gainCode,
  input  logic              resSel,
  input  logic              errClr,
  output logic              errFlag,
  output logic              busy
);

  settleCtrl_t ctrl;
  logic        timerBusy;

  settle_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .convStart (convStart),
    .errClr    (errClr),
    .timerBusy (timerBusy),
    .ctrl      (ctrl)
  );

  settle_datapath #(
    .GAIN_W    (GAIN_W),
    .CLK_MHZ   (CLK_MHZ),
    .FAST12_US (FAST12_US),
    .SLOW12_US (SLOW12_US),
    .FAST16_US (FAST16_US),
    .SLOW16_US (SLOW16_US)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .gainCode  (gainCode),
    .resSel    (resSel),
    .timerBusy (timerBusy),
    .errFlag   (errFlag)
  );

  assign busy = timerBusy;

  // R5: a start during the window raises the flag
  p_busy_start_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    convStart && busy |=> errFlag);

  // R6: a start outside the window leaves the flag alone
  p_idle_start_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    convStart && !busy && !errClr |=> $stable(errFlag));

endmodule

// File: tb/tb_settle_monitor.sv
module tb_settle_monitor;

  localparam int CLK_MHZ = 2;
  localparam int N_F12 = 10 * CLK_MHZ;
  localparam int N_S12 = 30 * CLK_MHZ;
  localparam int N_F16 = 5 * CLK_MHZ;
  localparam int N_S16 = 20 * CLK_MHZ;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       convStart = 1'b0;
  logic [2:0] gainCode = '0;
  logic       resSel = 1'b0;
  logic       errClr = 1'b0;
  logic       errFlag;
  logic       busy;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  settle_monitor #(.GAIN_W(3), .CLK_MHZ(CLK_MHZ)) dut (
    .clk(clk), .rstN(rstN), .convStart(convStart), .gainCode(gainCode),
    .resSel(resSel), .errClr(errClr), .errFlag(errFlag), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doStart(input int g, input bit r);
    convStart = 1'b1;
    gainCode  = 3'(g);
    resSel    = r;
    @(negedge clk);
    convStart = 1'b0;
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clearFlag();
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
  endtask

  task automatic waitIdle();
    int n;
    busyLen(n);
    @(negedge clk);
  endtask

  task automatic testReset();
    check("R1 errFlag after reset", errFlag, 0);
    check("R1 busy after reset", busy, 0);
  endtask

  task automatic testWindow(input string tag, input int g, input bit r, input int nCyc);
    int n;
    doStart(g, r);
    busyLen(n);
    check(tag, n, nCyc - 1);
    check({tag, " no flag"}, errFlag, 0);
    @(negedge clk);
  endtask

  task automatic testSpacing();
    doStart(0, 0);
    repeat (N_F12 - 1) @(negedge clk);
    doStart(0, 0);
    check("R6 start at exact window end", errFlag, 0);
    waitIdle();
    doStart(0, 0);
    repeat (N_F12 - 2) @(negedge clk);
    doStart(0, 0);
    check("R5 start one cycle early", errFlag, 1);
    waitIdle();
  endtask

  task automatic testSticky();
    repeat (30) @(negedge clk);
    check("R7 flag held while idle", errFlag, 1);
    clearFlag();
    check("R7 flag cleared", errFlag, 0);
  endtask

  task automatic testClearRace();
    doStart(0, 0);
    repeat (3) @(negedge clk);
    errClr = 1'b1;
    doStart(0, 0);
    errClr = 1'b0;
    check("R8 violation beats clear", errFlag, 1);
    waitIdle();
    clearFlag();
  endtask

  task automatic testRestart();
    int n;
    doStart(0, 0);
    repeat (4) @(negedge clk);
    doStart(0, 0);
    check("R9 early restart flags", errFlag, 1);
    busyLen(n);
    check("R9 window from latest start", n, N_F12 - 1);
    @(negedge clk);
    clearFlag();
  endtask

  task automatic testGainHold();
    int n;
    doStart(0, 0);
    gainCode = 3'd5;
    resSel   = 1'b1;
    busyLen(n);
    check("R10 window fixed at start", n, N_F12 - 1);
    @(negedge clk);
  endtask

  task automatic testMidReset();
    int n;
    doStart(5, 0);
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    check("R12 busy cleared by reset", busy, 0);
    doStart(5, 0);
    check("R12 first start after reset", errFlag, 0);
    busyLen(n);
    check("R12 fresh window", n, N_S12 - 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    for (int g = 0; g <= 4; g++) testWindow("R2 12-bit low gain window", g, 0, N_F12);
    for (int g = 5; g <= 6; g++) testWindow("R3 12-bit high gain window", g, 0, N_S12);
    for (int g = 0; g <= 1; g++) testWindow("R4 16-bit short window", g, 1, N_F16);
    for (int g = 2; g <= 3; g++) testWindow("R4 16-bit long window", g, 1, N_S16);
    testWindow("R11 12-bit code 7", 7, 0, N_S12);
    for (int g = 4; g <= 7; g++) testWindow("R11 16-bit unused code", g, 1, N_S16);
    testSpacing();
    testSticky();
    testClearRace();
    testRestart();
    testGainHold();
    testMidReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule